// File: doc/BRIEF.md
# Overflow-Race Frequency Steering Comparator

This block decides, once per comparison window, whether a locally generated clock is running slower or faster than a reference clock. It then nudges a frequency-control word by one step in the matching direction. Both clocks arrive already divided, as single-cycle rising-edge tick pulses in the system clock domain. Each tick stream drives its own small binary race counter. When the local counter takes its terminal tick, the block asks whether the reference counter has wrapped since the previous window. If it has, the reference is faster and the control word is raised. If it has not, the control word is lowered.

The control word lives in a saturating up/down counter that is loaded with a programmable start value at reset. A registered output multiplexer presents either that loop value or a word supplied by the user, which lets the oscillator be driven directly while the loop keeps tracking in the background. One-cycle raise and lower strobes mark every comparison.

Top module: `frc_lock_steer`

## Requirements
- R1: While `rst` is high, the control counter loads `init_word`, `freq_word` shows `init_word`, both strobes are low, and all race state is cleared.
- R2: A comparison happens on the cycle of the 2^RACE_W-th `loc_tick` since reset or since the last comparison (16 ticks by default), and never before it.
- R3: If the reference counter took its 2^RACE_W-th `ref_tick` in the window, before the comparison, the control word rises by 1 and `step_up` is high for the cycle after the comparison.
- R4: If the reference counter did not wrap in the window, the control word falls by 1 and `step_dn` is high for the cycle after the comparison.
- R5: A reference wrap that lands in the same cycle as the comparison counts as coming first, so the word rises.
- R6: At each comparison both race counters and the sticky reference-wrap flag are cleared, so reference ticks never carry into the next window.
- R7: A raise while the control word is all ones leaves it at all ones.
- R8: A lower while the control word is zero leaves it at zero.
- R9: `step_up` and `step_dn` are never high together. Each lasts exactly one cycle. The control word changes only on a comparison.
- R10: One cycle after `use_user` is high, `freq_word` equals the `user_word` of the previous cycle. With `use_user` low, `freq_word` shows the control word one cycle late. The loop keeps stepping in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_word | input | CTRL_W | Start value for the control counter |
| user_word | input | CTRL_W | User frequency word |
| use_user | input | 1 | 1 selects `user_word` on the output |
| ref_tick | input | 1 | Rising-edge pulse of the divided reference clock |
| loc_tick | input | 1 | Rising-edge pulse of the divided local clock |
| freq_word | output | CTRL_W | Registered frequency word to the oscillator |
| step_up | output | 1 | Raise strobe, one cycle after a comparison |
| step_dn | output | 1 | Lower strobe, one cycle after a comparison |

## Verification
The comparison is decided on the clock edge that takes the 16th local tick. The strobes are therefore due one cycle after that tick is driven, and the new `freq_word` is due one cycle after the strobes, because the output stage adds its own register. A user word appears one cycle after it is presented. The bench drives every input and samples every output on falling edges. It checks the strobes on the first falling edge after the comparison edge and the word on the second. It also confirms that no strobe appears after the 15th local tick.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_RAISE = 2'b01,
    STEP_LOWER = 2'b10
  } step_e;
endpackage

// File: rtl/frc_race_cnt.sv
// Plain binary race counter; term marks the tick taken while at all ones.
module frc_race_cnt #(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  output logic term
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  assign term = tick && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  // R2: without a tick or a clear the race count holds
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt_q));

  // R6: a clear always empties the counter
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/frc_updown.sv
// Saturating up/down control counter.
module frc_updown
  import frc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] init_val,
  input  step_e        step,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] VMAX = '1;
  localparam logic [W-1:0] VMIN = '0;

  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= init_val;
    end else begin
      unique case (step)
        STEP_RAISE: if (val_q != VMAX) val_q <= val_q + 1'b1;
        STEP_LOWER: if (val_q != VMIN) val_q <= val_q - 1'b1;
        default:    val_q <= val_q;
      endcase
    end
  end

  assign val = val_q;

  assert_raise_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_RAISE && val_q != VMAX) |=> (val_q == $past(val_q) + 1'b1));
  assert_lower_dec_R4: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_LOWER && val_q != VMIN) |=> (val_q == $past(val_q) - 1'b1));
  assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_RAISE && val_q == VMAX) |=> (val_q == VMAX));
  assert_sat_low_R8: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_LOWER && val_q == VMIN) |=> (val_q == VMIN));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_HOLD) |=> $stable(val_q));
endmodule

// File: rtl/frc_lock_steer.sv
module frc_lock_steer
  import frc_pkg::*;
#(
  parameter int RACE_W = 4,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] init_word,
  input  logic [CTRL_W-1:0] user_word,
  input  logic              use_user,
  input  logic              ref_tick,
  input  logic              loc_tick,
  output logic [CTRL_W-1:0] freq_word,
  output logic              step_up,
  output logic              step_dn
);
  logic              ref_term;
  logic              loc_term;
  logic              cmp_now;
  logic              ref_wrapped_q;
  logic              ref_won;
  step_e             step_sel;
  logic [CTRL_W-1:0] ctrl_val;

  assign cmp_now = loc_term;

  frc_race_cnt #(.W(RACE_W)) u_ref_race (
    .clk(clk), .rst(rst), .tick(ref_tick), .clr(cmp_now), .term(ref_term)
  );

  frc_race_cnt #(.W(RACE_W)) u_loc_race (
    .clk(clk), .rst(rst), .tick(loc_tick), .clr(cmp_now), .term(loc_term)
  );

  // Sticky record of a reference wrap inside the current window
  always_ff @(posedge clk) begin
    if (rst || cmp_now) ref_wrapped_q <= 1'b0;
    else if (ref_term)  ref_wrapped_q <= 1'b1;
  end

  // A same-cycle wrap is taken as having come first
  assign ref_won = ref_wrapped_q || ref_term;

  always_comb begin
    step_sel = STEP_HOLD;
    if (cmp_now) step_sel = ref_won ? STEP_RAISE : STEP_LOWER;
  end

  frc_updown #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst(rst), .init_val(init_word), .step(step_sel), .val(ctrl_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_up   <= 1'b0;
      step_dn   <= 1'b0;
      freq_word <= init_word;
    end else begin
      step_up   <= (step_sel == STEP_RAISE);
      step_dn   <= (step_sel == STEP_LOWER);
      freq_word <= use_user ? user_word : ctrl_val;
    end
  end

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(step_up && step_dn));
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    (step_up || step_dn) |=> !(step_up || step_dn));
  assert_tie_raises_R5: assert property (@(posedge clk) disable iff (rst)
    (loc_term && ref_term) |=> step_up);
  assert_user_pass_R10: assert property (@(posedge clk) disable iff (rst)
    use_user |=> (freq_word == $past(user_word)));
endmodule

// File: tb/sim_frc_lock_steer.sv
module sim_frc_lock_steer;
  localparam int RACE_W = 4;
  localparam int CTRL_W = 8;
  localparam int SPAN   = 1 << RACE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CTRL_W-1:0] init_word = '0;
  logic [CTRL_W-1:0] user_word = '0;
  logic              use_user = 1'b0;
  logic              ref_tick = 1'b0;
  logic              loc_tick = 1'b0;
  logic [CTRL_W-1:0] freq_word;
  logic              step_up;
  logic              step_dn;

  int checks = 0;
  int failures = 0;
  int exp_ctrl = 0;

  always #10 clk = ~clk;

  frc_lock_steer #(.RACE_W(RACE_W), .CTRL_W(CTRL_W)) u0 (
    .clk(clk), .rst(rst), .init_word(init_word), .user_word(user_word),
    .use_user(use_user), .ref_tick(ref_tick), .loc_tick(loc_tick),
    .freq_word(freq_word), .step_up(step_up), .step_dn(step_dn)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic r, logic l);
    ref_tick = r;
    loc_tick = l;
    @(negedge clk);
  endtask

  task automatic do_reset(int init);
    rst = 1'b1;
    init_word = CTRL_W'(init);
    use_user = 1'b0;
    ref_tick = 1'b0;
    loc_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_ctrl = init;
  endtask

  // r_pre reference-only ticks, then SPAN local ticks; the last may carry a reference tick
  task automatic window(int r_pre, logic r_with, string req);
    bit up;
    for (int i = 0; i < r_pre; i++) cyc(1'b1, 1'b0);
    for (int i = 0; i < SPAN - 1; i++) cyc(1'b0, 1'b1);
    chk("R2 no early compare", int'(step_up | step_dn), 0);
    cyc(r_with, 1'b1);
    up = (r_pre >= SPAN) || (r_pre == SPAN - 1 && r_with);
    chk({req, " step_up"}, int'(step_up), int'(up));
    chk({req, " step_dn"}, int'(step_dn), int'(!up));
    if (up)  exp_ctrl = (exp_ctrl == (1 << CTRL_W) - 1) ? exp_ctrl : exp_ctrl + 1;
    else     exp_ctrl = (exp_ctrl == 0) ? 0 : exp_ctrl - 1;
    cyc(1'b0, 1'b0);
    chk("R9 strobe one cycle", int'(step_up | step_dn), 0);
    if (use_user) chk({req, " user word held"}, int'(freq_word), int'(user_word));
    else          chk({req, " freq_word"}, int'(freq_word), exp_ctrl);
  endtask

  task automatic t_reset();
    @(negedge clk);
    do_reset(8'h80);
    chk("R1 freq_word", int'(freq_word), 8'h80);
    chk("R1 strobes", int'(step_up | step_dn), 0);
    cyc(1'b0, 1'b0);
    chk("R1 ctrl loaded", int'(freq_word), 8'h80);
  endtask

  task automatic t_raise_lower();
    window(20, 1'b0, "R3 raise");
    window(SPAN, 1'b0, "R3 exact wrap");
    window(5, 1'b0, "R4 lower");
    window(SPAN - 1, 1'b0, "R4 one short");
  endtask

  task automatic t_tie();
    window(SPAN - 1, 1'b1, "R5 tie");
  endtask

  task automatic t_clear();
    window(10, 1'b0, "R6 first half");
    window(10, 1'b0, "R6 no carry");
  endtask

  task automatic t_sat_high();
    do_reset(8'hFE);
    window(SPAN, 1'b0, "R7 to max");
    window(SPAN, 1'b0, "R7 saturate");
    window(SPAN, 1'b0, "R7 saturate again");
  endtask

  task automatic t_sat_low();
    do_reset(8'h01);
    window(0, 1'b0, "R8 to zero");
    window(0, 1'b0, "R8 saturate");
  endtask

  task automatic t_user();
    do_reset(8'h40);
    use_user = 1'b1;
    user_word = 8'h5A;
    cyc(1'b0, 1'b0);
    chk("R10 user passes", int'(freq_word), 8'h5A);
    window(SPAN, 1'b0, "R10 loop in user mode");
    use_user = 1'b0;
    cyc(1'b0, 1'b0);
    chk("R10 loop value back", int'(freq_word), exp_ctrl);
    chk("R10 loop stepped", exp_ctrl, 8'h41);
  endtask

  initial begin
    t_reset();
    t_raise_lower();
    t_tie();
    t_clear();
    t_sat_high();
    t_sat_low();
    t_user();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule